// File: doc/BRIEF.md
# Age-Addressed Operand Belt

This block stands in for a general-purpose register file. It keeps the most recent `SLOTS` results as values that cannot be changed once written. Producers never name a destination: each new result enters at the front, every older value moves one position back, and once the belt is full the oldest value drops off the end. Consumers name an operand by its age, where position 0 is the newest value, position 1 the one before it, and so on.

Storage is a circular buffer with a head pointer. Advancing the belt changes only the head, and stored data never moves. A read position is turned into a physical slot as (head − position) mod `SLOTS`. Every slot holds a 3-bit type tag next to its data. The tag gives the element width and says whether the value is a scalar or a 4-element vector. The block clears the data bits that the tag marks as unused when the value is written. Several drop lanes can write in the same cycle, for example a quotient and a remainder from one operation. A side port lets a save/restore unit read any value together with its tag (spill) and push a saved value back onto the front (fill).

Top module: `belt_store`

## Requirements
- R1: After a synchronous active-low reset, every read port and the spill port report `valid`=0 with data and tag all zero.
- R2: A single value dropped in cycle t reads at position 0 from cycle t+1. A value that was at position p moves to position p+1.
- R3: When K lanes drop in one cycle, their values take positions 0..K−1 in lane order: drop port 0 first, then higher drop ports, then the fill lane last. Every older value moves back by K.
- R4: Reads in a cycle return the belt as it stood before that cycle's drops.
- R5: A read at a position greater than or equal to the number of values dropped since reset (saturating at `SLOTS`) returns `valid`=0 with zero data and tag. Once the belt is full, the oldest value is discarded on each drop.
- R6: The tag written with a value comes back unchanged with that value at every later position. The tag encoding is bit 2 = vector and bits 1:0 = element width code (0=8, 1=16, 2=32, 3=64 bits).
- R7: Stored data keeps only its significant low bits and clears the rest. A scalar keeps the element width. A vector keeps 4 × the element width, capped at `DATA_W`.
- R8: The spill port reads any position with its tag, under the same rules as a read port. A fill drops its data and tag at the front through the last lane.
- R9: In a cycle with no drop the belt is unchanged, so the same position returns the same result in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drop_en | input | DROP_PORTS | Per-lane drop strobe |
| drop_data | input | DROP_PORTS×DATA_W | Per-lane result data |
| drop_tag | input | DROP_PORTS×3 | Per-lane type tag |
| fill_en | input | 1 | Drop a restored value |
| fill_data | input | DATA_W | Restored data |
| fill_tag | input | 3 | Restored tag |
| rd_pos | input | READ_PORTS×log2(SLOTS) | Operand age per read port |
| rd_data | output | READ_PORTS×DATA_W | Operand data |
| rd_tag | output | READ_PORTS×3 | Operand tag |
| rd_valid | output | READ_PORTS | Position holds a value |
| spill_pos | input | log2(SLOTS) | Age of the value to save |
| spill_data | output | DATA_W | Data to save |
| spill_tag | output | 3 | Tag to save |
| spill_valid | output | 1 | Spill position holds a value |

## Verification
Assertions run on every cycle and check four things. The fill count stays within `SLOTS` and never shrinks. No two lanes target the same physical slot. A cycle without a drop leaves every read result unchanged. A value dropped on port 0 is visible at position 0 with its tag one cycle later. Lane ordering across simultaneous drops, tag-driven masking, saturation and the discard of the oldest value, the pre-drop view of same-cycle reads, and spill/fill round trips can only be shown by the bench. It does so through directed scenarios and a seeded random run compared against an age-ordered reference model.

// File: rtl/belt_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the operand belt.
// Assumes: tag bit 2 = vector, bits 1:0 = element width code (8 << code bits).
package belt_pkg;
    localparam int TAG_W = 3;

    // Number of significant data bits a tag describes (before capping to slot width).
    function automatic int tag_sig_bits(input logic [TAG_W-1:0] tag);
        int elem;
        elem = 8 << tag[1:0];
        return tag[2] ? 4 * elem : elem;
    endfunction
endpackage

// File: rtl/belt_head.sv
`timescale 1ns/1ps
// Head pointer and fill count for the belt, plus translation of each drop lane
// into the physical slot it writes this cycle.
// Assumes: SLOTS is a power of two and LANES <= SLOTS, so targets never collide.
module belt_head #(
    parameter int SLOTS = 8,
    parameter int LANES = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [LANES-1:0]                   lane_v,
    output logic [$clog2(SLOTS)-1:0]           head_q,
    output logic [$clog2(SLOTS):0]             cnt_q,
    output logic [LANES-1:0][$clog2(SLOTS)-1:0] lane_phys
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int ND_W  = $clog2(LANES + 1);
    localparam logic [IDX_W+1:0] FULL = (IDX_W + 2)'(SLOTS);

    logic [ND_W-1:0]  n_drop;
    logic [IDX_W-1:0] rank;
    logic [IDX_W+1:0] cnt_sum;

    // Count the active lanes and give each one its slot: rank r lands at head + K - r.
    always_comb begin
        n_drop = '0;
        for (int l = 0; l < LANES; l++) begin
            n_drop = n_drop + ND_W'(lane_v[l]);
        end
        rank = '0;
        for (int l = 0; l < LANES; l++) begin
            lane_phys[l] = head_q + IDX_W'(n_drop) - rank;
            if (lane_v[l]) begin
                rank = rank + 1'b1;
            end
        end
        cnt_sum = {1'b0, cnt_q} + (IDX_W + 2)'(n_drop);
    end

    // Advance the head by the number of drops and saturate the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            head_q <= head_q + IDX_W'(n_drop);
            cnt_q  <= (cnt_sum > FULL) ? FULL[IDX_W:0] : cnt_sum[IDX_W:0];
        end
    end

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL[IDX_W:0]);

    a_r5_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q >= $past(cnt_q));

    // R3: simultaneous lanes must land in distinct physical slots.
    for (genvar a = 0; a < LANES; a++) begin : g_pa
        for (genvar b = a + 1; b < LANES; b++) begin : g_pb
            a_r3_distinct_targets: assert property (@(posedge clk) disable iff (!rst_n)
                (lane_v[a] && lane_v[b]) |-> lane_phys[a] != lane_phys[b]);
        end
    end
endmodule

// File: rtl/belt_slots.sv
`timescale 1ns/1ps
// Physical slot storage. Each slot takes at most one lane per cycle; data is
// trimmed to the bits its tag marks as significant when written.
// Assumes: lane targets from belt_head are distinct among active lanes.
module belt_slots
    import belt_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 64,
    parameter int LANES  = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [LANES-1:0]                    lane_v,
    input  logic [LANES-1:0][$clog2(SLOTS)-1:0] lane_phys,
    input  logic [LANES-1:0][DATA_W-1:0]        lane_data,
    input  logic [LANES-1:0][TAG_W-1:0]         lane_tag,
    output logic [SLOTS-1:0][DATA_W-1:0]        slot_data,
    output logic [SLOTS-1:0][TAG_W-1:0]         slot_tag
);
    localparam int IDX_W = $clog2(SLOTS);

    // Clear bits above the significant width named by the tag.
    function automatic logic [DATA_W-1:0] trim(input logic [DATA_W-1:0] d,
                                               input logic [TAG_W-1:0]  t);
        logic [DATA_W-1:0] m;
        int sig;
        sig = tag_sig_bits(t);
        for (int b = 0; b < DATA_W; b++) begin
            m[b] = (b < sig);
        end
        return d & m;
    endfunction

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Write this slot from whichever active lane targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_data[s] <= '0;
                slot_tag[s]  <= '0;
            end else begin
                for (int l = 0; l < LANES; l++) begin
                    if (lane_v[l] && lane_phys[l] == IDX_W'(s)) begin
                        slot_data[s] <= trim(lane_data[l], lane_tag[l]);
                        slot_tag[s]  <= lane_tag[l];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/belt_read_port.sv
`timescale 1ns/1ps
// One age-addressed read port: maps a position to its physical slot and
// reports whether a value has ever been dropped that far back.
// Assumes: SLOTS is a power of two, so index wrap is plain truncation.
module belt_read_port
    import belt_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 64
) (
    input  logic [$clog2(SLOTS)-1:0]     head,
    input  logic [$clog2(SLOTS):0]       cnt,
    input  logic [$clog2(SLOTS)-1:0]     pos,
    input  logic [SLOTS-1:0][DATA_W-1:0] slot_data,
    input  logic [SLOTS-1:0][TAG_W-1:0]  slot_tag,
    output logic [DATA_W-1:0]            data,
    output logic [TAG_W-1:0]             tag,
    output logic                         valid
);
    logic [$clog2(SLOTS)-1:0] phys;

    // Translate the age to a slot and suppress positions never written.
    always_comb begin
        phys  = head - pos;
        valid = {1'b0, pos} < cnt;
        data  = valid ? slot_data[phys] : '0;
        tag   = valid ? slot_tag[phys]  : '0;
    end
endmodule

// File: rtl/belt_store.sv
`timescale 1ns/1ps
// Operand belt top: drop lanes (result ports then the fill lane) feed a
// circular slot store; read ports and the spill port address values by age.
// Assumes: SLOTS is 8, 16 or 32, and DROP_PORTS + 1 <= SLOTS.
module belt_store
    import belt_pkg::*;
#(
    parameter int SLOTS      = 8,
    parameter int DATA_W     = 64,
    parameter int DROP_PORTS = 2,
    parameter int READ_PORTS = 3
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [DROP_PORTS-1:0]                    drop_en,
    input  logic [DROP_PORTS-1:0][DATA_W-1:0]        drop_data,
    input  logic [DROP_PORTS-1:0][2:0]               drop_tag,
    input  logic                                     fill_en,
    input  logic [DATA_W-1:0]                        fill_data,
    input  logic [2:0]                               fill_tag,
    input  logic [READ_PORTS-1:0][$clog2(SLOTS)-1:0] rd_pos,
    output logic [READ_PORTS-1:0][DATA_W-1:0]        rd_data,
    output logic [READ_PORTS-1:0][2:0]               rd_tag,
    output logic [READ_PORTS-1:0]                    rd_valid,
    input  logic [$clog2(SLOTS)-1:0]                 spill_pos,
    output logic [DATA_W-1:0]                        spill_data,
    output logic [2:0]                               spill_tag,
    output logic                                     spill_valid
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int LANES = DROP_PORTS + 1;

    logic [LANES-1:0]              lane_v;
    logic [LANES-1:0][DATA_W-1:0]  lane_data;
    logic [LANES-1:0][TAG_W-1:0]   lane_tag;
    logic [LANES-1:0][IDX_W-1:0]   lane_phys;
    logic [IDX_W-1:0]              head;
    logic [IDX_W:0]                cnt;
    logic [SLOTS-1:0][DATA_W-1:0]  slot_data;
    logic [SLOTS-1:0][TAG_W-1:0]   slot_tag;

    // Order lanes: result ports first, fill lane last.
    always_comb begin
        lane_v    = {fill_en, drop_en};
        lane_data = {fill_data, drop_data};
        lane_tag  = {fill_tag, drop_tag};
    end

    belt_head #(.SLOTS(SLOTS), .LANES(LANES)) u_head (
        .clk(clk), .rst_n(rst_n), .lane_v(lane_v),
        .head_q(head), .cnt_q(cnt), .lane_phys(lane_phys)
    );

    belt_slots #(.SLOTS(SLOTS), .DATA_W(DATA_W), .LANES(LANES)) u_slots (
        .clk(clk), .rst_n(rst_n), .lane_v(lane_v), .lane_phys(lane_phys),
        .lane_data(lane_data), .lane_tag(lane_tag),
        .slot_data(slot_data), .slot_tag(slot_tag)
    );

    for (genvar g = 0; g < READ_PORTS; g++) begin : g_rd
        belt_read_port #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_rd (
            .head(head), .cnt(cnt), .pos(rd_pos[g]),
            .slot_data(slot_data), .slot_tag(slot_tag),
            .data(rd_data[g]), .tag(rd_tag[g]), .valid(rd_valid[g])
        );

        a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !(|lane_v) |=> (rd_pos[g] == $past(rd_pos[g])) ->
                (rd_data[g] == $past(rd_data[g]) && rd_valid[g] == $past(rd_valid[g])));
    end

    belt_read_port #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_spill (
        .head(head), .cnt(cnt), .pos(spill_pos),
        .slot_data(slot_data), .slot_tag(slot_tag),
        .data(spill_data), .tag(spill_tag), .valid(spill_valid)
    );

    a_r2_front_newest: assert property (@(posedge clk) disable iff (!rst_n)
        lane_v[0] |=> (rd_pos[0] == '0) ->
            (rd_valid[0] && rd_tag[0] == $past(lane_tag[0])));
endmodule

// File: tb/belt_store_tb.sv
`timescale 1ns/1ps
module belt_store_tb;
    localparam int N = 8, DW = 64, DP = 2, RP = 3, IW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [DP-1:0]          drop_en = '0;
    logic [DP-1:0][DW-1:0]  drop_data = '0;
    logic [DP-1:0][2:0]     drop_tag = '0;
    logic                   fill_en = 1'b0;
    logic [DW-1:0]          fill_data = '0;
    logic [2:0]             fill_tag = '0;
    logic [RP-1:0][IW-1:0]  rd_pos = '0;
    logic [RP-1:0][DW-1:0]  rd_data;
    logic [RP-1:0][2:0]     rd_tag;
    logic [RP-1:0]          rd_valid;
    logic [IW-1:0]          spill_pos = '0;
    logic [DW-1:0]          spill_data;
    logic [2:0]             spill_tag;
    logic                   spill_valid;

    belt_store #(.SLOTS(N), .DATA_W(DW), .DROP_PORTS(DP), .READ_PORTS(RP)) u_dut (
        .clk(clk), .rst_n(rst_n), .drop_en(drop_en), .drop_data(drop_data),
        .drop_tag(drop_tag), .fill_en(fill_en), .fill_data(fill_data),
        .fill_tag(fill_tag), .rd_pos(rd_pos), .rd_data(rd_data), .rd_tag(rd_tag),
        .rd_valid(rd_valid), .spill_pos(spill_pos), .spill_data(spill_data),
        .spill_tag(spill_tag), .spill_valid(spill_valid)
    );

    logic [DW-1:0] md [N];
    logic [2:0]    mt [N];
    int mcnt = 0, checks = 0, fails = 0;
    bit done = 0;

    function automatic logic [DW-1:0] exp_trim(input logic [DW-1:0] d, input logic [2:0] t);
        int bits;
        bits = (t[2] ? 32 : 8) << t[1:0];
        if (bits >= DW) return d;
        return d & ((64'd1 << bits) - 64'd1);
    endfunction

    task automatic chk(string lbl, int port, logic [IW-1:0] pos, logic v,
                       logic [DW-1:0] d, logic [2:0] t);
        logic ev; logic [DW-1:0] ed; logic [2:0] et;
        ev = int'(pos) < mcnt;
        ed = ev ? md[pos] : '0;
        et = ev ? mt[pos] : '0;
        checks++;
        if (v !== ev || d !== ed || t !== et) begin
            fails++;
            $display("FAIL %s port%0d pos%0d: got v=%0b d=%h t=%h exp v=%0b d=%h t=%h",
                     lbl, port, pos, v, d, t, ev, ed, et);
        end
    endtask

    task automatic check_val(string lbl, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", lbl, got, exp);
        end
    endtask

    task automatic compare_all(string lbl);
        for (int p = 0; p < RP; p++) chk(lbl, p, rd_pos[p], rd_valid[p], rd_data[p], rd_tag[p]);
        chk(lbl, RP, spill_pos, spill_valid, spill_data, spill_tag);
    endtask

    task automatic model_update();
        logic [DW-1:0] ld [DP+1];
        logic [2:0]    lt [DP+1];
        int k = 0;
        for (int p = 0; p < DP; p++) begin
            if (drop_en[p]) begin
                ld[k] = exp_trim(drop_data[p], drop_tag[p]); lt[k] = drop_tag[p]; k++;
            end
        end
        if (fill_en) begin
            ld[k] = exp_trim(fill_data, fill_tag); lt[k] = fill_tag; k++;
        end
        for (int p = N - 1; p >= k; p--) begin md[p] = md[p-k]; mt[p] = mt[p-k]; end
        for (int r = 0; r < k; r++) begin md[r] = ld[r]; mt[r] = lt[r]; end
        mcnt = (mcnt + k > N) ? N : mcnt + k;
    endtask

    // Check reads before the edge, advance model at the edge, clear strobes after.
    task automatic cycle(string lbl);
        #1;
        compare_all(lbl);
        @(posedge clk);
        if (rst_n) model_update();
        @(negedge clk);
        drop_en = '0;
        fill_en = 1'b0;
    endtask

    task automatic set_drop(int p, logic [DW-1:0] d, logic [2:0] t);
        drop_en[p] = 1'b1; drop_data[p] = d; drop_tag[p] = t;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin md[i] = '0; mt[i] = '0; end
        void'($urandom(32'd1789));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        rd_pos = {3'd7, 3'd3, 3'd0}; spill_pos = 3'd5;
        cycle("R1");
        checks++; if (rd_valid !== '0) begin fails++; $display("FAIL R1: got valid %b exp 000", rd_valid); end

        // R4: a drop is not visible in its own cycle
        rd_pos = '0; set_drop(0, 64'hAAAA_0000_0000_0001, 3'b011);
        #1; checks++;
        if (rd_valid[0] !== 1'b0) begin fails++; $display("FAIL R4: got valid 1 exp 0"); end
        cycle("R4");
        check_val("R2", rd_data[0], 64'hAAAA_0000_0000_0001);

        // R2: second drop pushes the first back
        set_drop(0, 64'hBBBB, 3'b011); cycle("R2");
        rd_pos = {3'd2, 3'd1, 3'd0};
        #1; check_val("R2", rd_data[1], 64'hAAAA_0000_0000_0001);
        cycle("R2");

        // R3 / R8: two ports plus fill in one cycle
        set_drop(0, 64'hC, 3'b011); set_drop(1, 64'hD, 3'b011);
        fill_en = 1'b1; fill_data = 64'hE; fill_tag = 3'b011;
        cycle("R3");
        #1; check_val("R3", rd_data[0], 64'hC); check_val("R3", rd_data[1], 64'hD);
        check_val("R8", rd_data[2], 64'hE);
        rd_pos = {3'd5, 3'd4, 3'd3};
        #1; check_val("R3", rd_data[0], 64'hBBBB);
        checks++; if (rd_valid[2] !== 1'b0) begin fails++; $display("FAIL R5: got valid 1 exp 0 at pos5"); end
        cycle("R5");

        // R7 / R6: masking by tag, tag kept
        set_drop(0, '1, 3'b000); set_drop(1, '1, 3'b100);
        fill_en = 1'b1; fill_data = '1; fill_tag = 3'b001;
        cycle("R7");
        rd_pos = {3'd2, 3'd1, 3'd0}; spill_pos = 3'd2;
        #1; check_val("R7", rd_data[0], 64'hFF);
        check_val("R7", rd_data[1], 64'hFFFF_FFFF);
        check_val("R7", rd_data[2], 64'hFFFF);
        check_val("R6", {61'd0, spill_tag}, 64'd1);
        cycle("R6");
        set_drop(0, '1, 3'b101); cycle("R7");
        rd_pos = '0; #1; check_val("R7", rd_data[0], '1);

        // R9: idle cycles change nothing
        rd_pos = {3'd6, 3'd3, 3'd1};
        cycle("R9"); cycle("R9"); cycle("R9");

        // R5: saturation discards the oldest
        for (int i = 1; i <= 10; i++) begin set_drop(0, 64'(i), 3'b011); cycle("R5"); end
        rd_pos = {3'd7, 3'd1, 3'd0};
        #1; check_val("R5", rd_data[2], 64'd3); check_val("R5", rd_data[0], 64'd10);
        check_val("R5", {63'd0, rd_valid[2]}, 64'd1);
        cycle("R5");

        // Random mix
        for (int c = 0; c < 4000; c++) begin
            for (int p = 0; p < DP; p++) begin
                drop_en[p] = ($urandom % 3) == 0;
                drop_data[p] = {$urandom, $urandom};
                drop_tag[p] = 3'($urandom);
            end
            fill_en = ($urandom % 5) == 0;
            fill_data = {$urandom, $urandom};
            fill_tag = 3'($urandom);
            for (int p = 0; p < RP; p++) rd_pos[p] = IW'($urandom);
            spill_pos = IW'($urandom);
            cycle("R3");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule